// File: doc/BRIEF.md
# Host Control Port with Shared Memory Window

This block is the slave end of an asynchronous processor bus. The bus has a 16-bit data path, a 9-bit word address, and three active-low strobes: select, read and write. The block decodes the 512-word space into several regions:

- a bank of fourteen control words;
- a strobe address that fires a single-cycle pulse;
- a read-only status word;
- four offset words;
- a 256-word upper window.

In the upper window, reads return words from an external capture memory and writes go to an external phase-error table. The block drives only the port signals of those memories; the memories are not part of it.

Writes cross into the core clock through a synchroniser on the write strobe. Each access produces exactly one internal commit. Reads are combinational from the address, and the block raises an output enable for the external tri-state data pads.

Holding the read strobe low puts the port into a legacy protocol. In that protocol the select line frames each access and the write strobe acts as a read/write level.

Top module: `hostport_ctl`

## Requirements
- R1: After reset, all control and offset words read zero, `os_pulse` and `pe_we` are low, and `hb_oe` is low.
- R2: In normal mode (read strobe high), a write to words 0–13 or 16–19 is committed exactly once after the write strobe returns high. Reading the word back then returns the written value.
- R3: `hb_oe` is high only while select and read strobe are low and the write strobe is high; it is low whenever the write strobe is low. While it is high, `hb_dout` carries the word at `hb_addr`.
- R4: A write to word 14 raises `os_pulse` for exactly one clock cycle and changes no stored word. Word 14 reads as zero.
- R5: Word 15 reads the `stat_in` input, and writes to word 15 change no stored word.
- R6: Words 20–255 read as zero, and writes to them change no stored word and produce no pulse.
- R7: For addresses 256–511, `cap_raddr` equals the low 8 address bits and `hb_dout` returns `cap_rdata`.
- R8: A write to addresses 256–511 gives exactly one one-cycle `pe_we` pulse. During that pulse `pe_waddr` holds the low 8 address bits and `pe_wdata` holds the bus data. No stored word changes.
- R9: In legacy mode (read strobe held low), a write is taken once per falling edge of select while the write strobe is low. The commit lands while select is still low.
- R10: In legacy mode, a read drives the selected word while select is low and the write strobe is high.
- R11: A write strobe held low for many cycles still yields exactly one commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_cs_n | input | 1 | Select, active low |
| hb_rd_n | input | 1 | Read strobe, active low; held low selects legacy mode |
| hb_wr_n | input | 1 | Write strobe, active low; read/write level in legacy mode |
| hb_addr | input | 9 | Word address |
| hb_din | input | 16 | Data from the bus pads |
| hb_dout | output | 16 | Data to the bus pads |
| hb_oe | output | 1 | Pad output enable |
| stat_in | input | 16 | Status value returned at word 15 |
| ctl_regs | output | 224 | Fourteen control words, word k at bits 16k+15:16k |
| dc_regs | output | 64 | Four offset words, word k at bits 16k+15:16k |
| os_pulse | output | 1 | One-cycle strobe from a write to word 14 |
| cap_raddr | output | 8 | Capture memory read address |
| cap_rdata | input | 16 | Capture memory read data, combinational |
| pe_we | output | 1 | Phase-error table write pulse |
| pe_waddr | output | 8 | Phase-error table write address |
| pe_wdata | output | 16 | Phase-error table write data |

## Verification
The assertions assume that the host holds address and data steady from the start of a write strobe until at least three core cycles after the strobe ends. They also assume that a low write strobe lasts at least three core cycles, so the synchroniser sees it, and that the read strobe changes level only while the port is idle. The bench meets these assumptions by construction. Its write tasks keep select and the bus lines steady for three cycles after the strobe returns high, and they hold every strobe for five cycles or more. It switches to the legacy protocol only with select high, then waits for the mode level to synchronise before the first legacy access.

// File: rtl/hostport_pkg.sv
package hostport_pkg;

  typedef enum logic [2:0] {
    SEL_CTL,
    SEL_OS,
    SEL_STAT,
    SEL_DC,
    SEL_NONE,
    SEL_WIN
  } sel_e;

  // Region decode: control words first, then strobe, status, offsets.
  function automatic sel_e decode_addr(input int unsigned a,
                                       input int unsigned nctl,
                                       input int unsigned ndc,
                                       input int unsigned win);
    if (a >= win)             return SEL_WIN;
    if (a < nctl)             return SEL_CTL;
    if (a == nctl)            return SEL_OS;
    if (a == nctl + 1)        return SEL_STAT;
    if (a < nctl + 2 + ndc)   return SEL_DC;
    return SEL_NONE;
  endfunction

endpackage

// File: rtl/hp_wr_sync.sv
module hp_wr_sync #(
  parameter int AW = 9,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          wr_go,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);

  logic [2:0]    stb_q, stb_d;
  logic [1:0]    leg_q, leg_d;
  logic          go_d;
  logic          stb_rise, stb_fall, legacy, hold_en;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_comb begin
    stb_d    = {stb_q[1:0], ~cs_n & ~wr_n};
    leg_d    = {leg_q[0], ~rd_n};
    legacy   = leg_q[1];
    stb_rise = stb_q[1] & ~stb_q[2];
    stb_fall = ~stb_q[1] & stb_q[2];
    go_d     = legacy ? stb_rise : stb_fall;
    hold_en  = stb_q[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= '0;
      leg_q <= '0;
      wr_go <= 1'b0;
    end else begin
      stb_q <= stb_d;
      leg_q <= leg_d;
      wr_go <= go_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (hold_en) begin
      addr_q <= addr;
      data_q <= din;
    end
  end

  assign wr_addr = addr_q;
  assign wr_data = data_q;

  // R11: a strobe, however long, commits once
  p_single_go_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> !wr_go);

  // R2: a normal-mode commit follows the end of a synchronised strobe
  p_commit_after_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && !$past(leg_q[1])) |-> !stb_q[2]);

endmodule

// File: rtl/hp_regfile.sv
module hp_regfile
  import hostport_pkg::*;
#(
  parameter int AW   = 9,
  parameter int DW   = 16,
  parameter int NCTL = 14,
  parameter int NDC  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_go,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic [NCTL*DW-1:0] ctl_flat,
  output logic [NDC*DW-1:0]  dc_flat,
  output logic              os_pulse,
  output logic              pe_we,
  output logic [AW-2:0]     pe_waddr,
  output logic [DW-1:0]     pe_wdata
);

  localparam int WA      = AW - 1;
  localparam int WIN     = 1 << WA;
  localparam int DC_BASE = NCTL + 2;

  sel_e wsel;
  logic os_d, pe_d;

  always_comb begin
    wsel = decode_addr(32'(wr_addr), NCTL, NDC, WIN);
    os_d = wr_go && (wsel == SEL_OS);
    pe_d = wr_go && (wsel == SEL_WIN);
  end

  for (genvar g = 0; g < NCTL; g++) begin : g_ctl
    logic [DW-1:0] q;
    logic          en;
    assign en = wr_go && (wsel == SEL_CTL) && (wr_addr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wr_data;
    end
    assign ctl_flat[g*DW +: DW] = q;
  end

  for (genvar g = 0; g < NDC; g++) begin : g_dc
    logic [DW-1:0] q;
    logic          en;
    assign en = wr_go && (wsel == SEL_DC) && (wr_addr == AW'(DC_BASE + g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wr_data;
    end
    assign dc_flat[g*DW +: DW] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      os_pulse <= 1'b0;
      pe_we    <= 1'b0;
    end else begin
      os_pulse <= os_d;
      pe_we    <= pe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pe_waddr <= '0;
      pe_wdata <= '0;
    end else if (pe_d) begin
      pe_waddr <= wr_addr[WA-1:0];
      pe_wdata <= wr_data;
    end
  end

  // R4: strobe is one cycle wide
  p_os_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    os_pulse |=> !os_pulse);

  // R8: table write pulse is one cycle wide and never coincides with the strobe
  p_pe_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pe_we |=> !pe_we);
  p_pulse_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({os_pulse, pe_we}));

  // R6: stored words move only on a commit
  p_regs_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_go |=> ($stable(ctl_flat) && $stable(dc_flat)));

  // R4: a pulse leaves every stored word as it was
  p_pulse_no_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (os_d || pe_d) |=> ($stable(ctl_flat) && $stable(dc_flat)));

endmodule

// File: rtl/hp_rd_mux.sv
module hp_rd_mux
  import hostport_pkg::*;
#(
  parameter int AW   = 9,
  parameter int DW   = 16,
  parameter int NCTL = 14,
  parameter int NDC  = 4
) (
  input  logic [AW-1:0]      addr,
  input  logic [NCTL*DW-1:0] ctl_flat,
  input  logic [NDC*DW-1:0]  dc_flat,
  input  logic [DW-1:0]      stat_in,
  input  logic [DW-1:0]      cap_rdata,
  output logic [AW-2:0]      cap_raddr,
  output logic [DW-1:0]      rdata
);

  localparam int WIN     = 1 << (AW - 1);
  localparam int DC_BASE = NCTL + 2;

  sel_e rsel;

  always_comb begin
    rsel  = decode_addr(32'(addr), NCTL, NDC, WIN);
    rdata = '0;
    case (rsel)
      SEL_CTL: begin
        for (int k = 0; k < NCTL; k++)
          if (addr == AW'(k)) rdata = ctl_flat[k*DW +: DW];
      end
      SEL_DC: begin
        for (int k = 0; k < NDC; k++)
          if (addr == AW'(DC_BASE + k)) rdata = dc_flat[k*DW +: DW];
      end
      SEL_STAT: rdata = stat_in;
      SEL_WIN:  rdata = cap_rdata;
      default:  rdata = '0;
    endcase
  end

  assign cap_raddr = addr[AW-2:0];

endmodule

// File: rtl/hostport_ctl.sv
module hostport_ctl #(
  parameter int AW   = 9,
  parameter int DW   = 16,
  parameter int NCTL = 14,
  parameter int NDC  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hb_cs_n,
  input  logic               hb_rd_n,
  input  logic               hb_wr_n,
  input  logic [AW-1:0]      hb_addr,
  input  logic [DW-1:0]      hb_din,
  output logic [DW-1:0]      hb_dout,
  output logic               hb_oe,
  input  logic [DW-1:0]      stat_in,
  output logic [NCTL*DW-1:0] ctl_regs,
  output logic [NDC*DW-1:0]  dc_regs,
  output logic               os_pulse,
  output logic [AW-2:0]      cap_raddr,
  input  logic [DW-1:0]      cap_rdata,
  output logic               pe_we,
  output logic [AW-2:0]      pe_waddr,
  output logic [DW-1:0]      pe_wdata
);

  logic [1:0]    rst_q;
  logic          rst_core;
  logic          wr_go;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_core = rst_q[1];

  hp_wr_sync #(.AW(AW), .DW(DW)) u_sync (
    .clk     (clk),
    .rst_n   (rst_core),
    .cs_n    (hb_cs_n),
    .rd_n    (hb_rd_n),
    .wr_n    (hb_wr_n),
    .addr    (hb_addr),
    .din     (hb_din),
    .wr_go   (wr_go),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  hp_regfile #(.AW(AW), .DW(DW), .NCTL(NCTL), .NDC(NDC)) u_regs (
    .clk      (clk),
    .rst_n    (rst_core),
    .wr_go    (wr_go),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .ctl_flat (ctl_regs),
    .dc_flat  (dc_regs),
    .os_pulse (os_pulse),
    .pe_we    (pe_we),
    .pe_waddr (pe_waddr),
    .pe_wdata (pe_wdata)
  );

  hp_rd_mux #(.AW(AW), .DW(DW), .NCTL(NCTL), .NDC(NDC)) u_rd (
    .addr      (hb_addr),
    .ctl_flat  (ctl_regs),
    .dc_flat   (dc_regs),
    .stat_in   (stat_in),
    .cap_rdata (cap_rdata),
    .cap_raddr (cap_raddr),
    .rdata     (hb_dout)
  );

  // same condition serves both protocols: in legacy mode read strobe is low
  assign hb_oe = ~hb_cs_n & ~hb_rd_n & hb_wr_n;

  // R3: pads never drive while a write strobe is low
  p_oe_off_r3: assert property (@(posedge clk) disable iff (!rst_core)
    !hb_wr_n |-> !hb_oe);

endmodule

// File: tb/hostport_ctl_bench.sv
module hostport_ctl_bench;
  localparam int AW = 9;
  localparam int DW = 16;
  localparam logic [15:0] STAT = 16'h5A3C;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, cs_n, rd_n, wr_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic oe, os, pe_we;
  logic [14*DW-1:0] ctl;
  logic [4*DW-1:0] dc;
  logic [7:0] cap_raddr, pe_waddr;
  logic [DW-1:0] cap_rdata, pe_wdata;

  assign cap_rdata = {~cap_raddr, cap_raddr};

  hostport_ctl u_hostport_ctl (
    .clk(clk), .rst_n(rst_n), .hb_cs_n(cs_n), .hb_rd_n(rd_n), .hb_wr_n(wr_n),
    .hb_addr(addr), .hb_din(din), .hb_dout(dout), .hb_oe(oe), .stat_in(STAT),
    .ctl_regs(ctl), .dc_regs(dc), .os_pulse(os), .cap_raddr(cap_raddr),
    .cap_rdata(cap_rdata), .pe_we(pe_we), .pe_waddr(pe_waddr), .pe_wdata(pe_wdata)
  );

  int checks = 0, fails = 0;
  int os_cnt = 0, pe_cnt = 0;
  logic [7:0]  pe_last_a;
  logic [15:0] pe_last_d;
  logic [15:0] mdl [0:19];
  bit done = 0;

  // per-clock monitor of pulse outputs
  always @(negedge clk) begin
    if (rst_n) begin
      if (os) os_cnt++;
      if (pe_we) begin
        pe_cnt++;
        pe_last_a = pe_waddr;
        pe_last_d = pe_wdata;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(input int a);
    if (a >= 256) return {~8'(a), 8'(a)};
    if (a < 14 || (a >= 16 && a < 20)) return mdl[a];
    if (a == 15) return STAT;
    return 16'h0;
  endfunction

  function automatic bit stored(input int a);
    return (a < 14) || (a >= 16 && a < 20);
  endfunction

  task automatic wr_norm(input int a, input logic [15:0] d, input int hold);
    @(negedge clk); addr = AW'(a); din = d; cs_n = 0;
    @(negedge clk); wr_n = 0;
    repeat (hold) @(negedge clk);
    wr_n = 1;
    repeat (3) @(negedge clk);
    cs_n = 1;
    repeat (6) @(negedge clk);
    if (stored(a)) mdl[a] = d;
  endtask

  task automatic wr_leg(input int a, input logic [15:0] d, input string req);
    @(negedge clk); addr = AW'(a); din = d; wr_n = 0;
    @(negedge clk); cs_n = 0;
    repeat (4) @(negedge clk);
    chk({req, " oe off during write"}, 32'(oe), 0);
    repeat (4) @(negedge clk);
    if (stored(a)) begin
      mdl[a] = d;
      chk({req, " commit while select low"}, 32'(a < 14 ? ctl[a*16 +: 16] : dc[(a-16)*16 +: 16]), 32'(d));
    end
    cs_n = 1;
    @(negedge clk); wr_n = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic rd_chk(input string req, input int a, input bit legacy);
    @(negedge clk); addr = AW'(a); cs_n = 0;
    if (!legacy) rd_n = 0;
    #1;
    chk({req, " oe on"}, 32'(oe), 1);
    chk({req, " data"}, 32'(dout), 32'(exp_rd(a)));
    if (a >= 256) chk({req, " cap addr"}, 32'(cap_raddr), 32'(a & 255));
    @(negedge clk); cs_n = 1;
    if (!legacy) rd_n = 1;
    #1 chk({req, " oe off"}, 32'(oe), 0);
  endtask

  task automatic rd_all(input string req, input bit legacy);
    for (int a = 0; a < 22; a++) rd_chk(req, a, legacy);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    int o0, p0;
    logic [14*DW-1:0] c0;
    logic [4*DW-1:0]  d0;
    rst_n = 0; cs_n = 1; rd_n = 1; wr_n = 1; addr = '0; din = '0;
    for (int i = 0; i < 20; i++) mdl[i] = 16'h0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 ctl zero", 32'(|ctl), 0);
    chk("R1 dc zero", 32'(|dc), 0);
    chk("R1 no pulses", 32'({os, pe_we}), 0);
    chk("R1 oe low", 32'(oe), 0);

    // R2: normal writes to stored words
    wr_norm(0, 16'h1234, 5);
    wr_norm(5, 16'hBEEF, 6);
    wr_norm(13, 16'h8001, 5);
    wr_norm(16, 16'h0F0F, 5);
    wr_norm(19, 16'hCAFE, 7);
    chk("R2 ctl word 5 port", 32'(ctl[5*16 +: 16]), 32'h0000BEEF);
    chk("R2 dc word 3 port", 32'(dc[3*16 +: 16]), 32'h0000CAFE);
    rd_all("R2 R3 readback", 0);

    // R4: one-shot address
    o0 = os_cnt; p0 = pe_cnt; c0 = ctl; d0 = dc;
    wr_norm(14, 16'hFFFF, 5);
    chk("R4 one pulse cycle", 32'(os_cnt - o0), 1);
    chk("R4 no table write", 32'(pe_cnt - p0), 0);
    chk("R4 ctl unchanged", 32'(ctl == c0 && dc == d0), 1);
    rd_chk("R4 read zero", 14, 0);

    // R5: status port
    c0 = ctl; d0 = dc;
    wr_norm(15, 16'h7777, 5);
    chk("R5 write ignored", 32'(ctl == c0 && dc == d0), 1);
    rd_chk("R5 status", 15, 0);

    // R6: unused range
    o0 = os_cnt; p0 = pe_cnt;
    wr_norm(20, 16'h1111, 5);
    wr_norm(255, 16'h2222, 5);
    chk("R6 no store", 32'(ctl == c0 && dc == d0), 1);
    chk("R6 no pulse", 32'((os_cnt - o0) + (pe_cnt - p0)), 0);
    rd_chk("R6 read 20", 20, 0);
    rd_chk("R6 read 255", 255, 0);

    // R7: window reads
    rd_chk("R7 win 256", 256, 0);
    rd_chk("R7 win 300", 300, 0);
    rd_chk("R7 win 511", 511, 0);

    // R8: window write
    p0 = pe_cnt; o0 = os_cnt;
    wr_norm(256 + 7, 16'hA55A, 5);
    chk("R8 one table pulse", 32'(pe_cnt - p0), 1);
    chk("R8 table addr", 32'(pe_last_a), 7);
    chk("R8 table data", 32'(pe_last_d), 32'h0000A55A);
    chk("R8 no strobe", 32'(os_cnt - o0), 0);
    chk("R8 no store", 32'(ctl == c0 && dc == d0), 1);

    // R11: long strobe
    p0 = pe_cnt;
    wr_norm(511, 16'h0BAD, 60);
    chk("R11 single commit", 32'(pe_cnt - p0), 1);
    chk("R11 table addr", 32'(pe_last_a), 255);
    wr_norm(3, 16'h3333, 50);
    rd_chk("R11 long write word", 3, 0);

    // R9/R10: legacy protocol
    rd_n = 0;
    repeat (4) @(negedge clk);
    chk("R10 idle oe off", 32'(oe), 0);
    wr_leg(2, 16'h2B2B, "R9");
    wr_leg(17, 16'h1717, "R9");
    p0 = pe_cnt; o0 = os_cnt;
    wr_leg(256 + 200, 16'hD00D, "R9");
    chk("R9 table pulse", 32'(pe_cnt - p0), 1);
    chk("R9 table addr", 32'(pe_last_a), 200);
    chk("R9 table data", 32'(pe_last_d), 32'h0000D00D);
    wr_leg(14, 16'h0000, "R9");
    chk("R9 strobe pulse", 32'(os_cnt - o0), 1);
    rd_all("R10 legacy read", 1);
    rd_chk("R10 legacy win", 400, 1);
    rd_n = 1;
    repeat (4) @(negedge clk);

    done = 1;
    finish_run();
  end
endmodule